// File: doc/BRIEF.md
# Sleep-Mode Pin State Controller

This block holds a small power-management configuration word and uses it to decide how the memory-interface control pins, the PC-card control pins and the fast oscillator behave while the chip sleeps. Software reads and writes the word through a simple register port. A sleep sequencer elsewhere raises `sleep_in`. From then on the block either tri-states each pin group or drives it to levels programmed in a separate sleep-state register, and it decides whether the fast oscillator may stop.

Outside sleep, every controlled pin passes its functional value through with its output enable asserted. Each pin output, each enable and the oscillator run flag come from a register. A change on any input therefore reaches the pads one clock later, free of combinational glitches. The pad cells and the sleep-state register are outside this block.

Top module: `sleep_pin_ctrl`

## Requirements
- R1: When `reg_we` is high at a rising clock edge, bits [2:0] of `reg_wdata` are stored. Bit 0 is the oscillator-stop enable, bit 1 is the card-control float and bit 2 is the memory-control float. `reg_rdata` shows the stored bits in the same positions in the same cycle.
- R2: `reg_rdata[31:3]` always reads zero, and values written to those bits are discarded.
- R3: `rst`, `wdt_rst` or `gpio_rst` high at a clock edge clears all three stored bits. A reset takes priority over a write in the same cycle.
- R4: When `sleep_in` is low, every pin output equals its functional input and every output enable is 1.
- R5: When in sleep with the memory-float bit clear, `mem_cs_o[k]` for k>=1 equals `mem_slp_cs[k-1]`. `mem_cs_o[0]`, `mem_we_o` and `mem_oe_o` are driven 1, and all memory enables are 1.
- R6: When in sleep with the memory-float bit set, all chip-select, write-enable and output-enable pins have enable 0 and drive value 0.
- R7: When in sleep with the card-float bit clear, `card_ctl_o` equals `card_slp_ctl` and `card_sel_o` equals `card_slp_sel`, with all card enables at 1. The bit order of `card_ctl_o` is [0] output enable, [1] write enable, [2] I/O write, [3] I/O read, [4] card enable 1, [5] card enable 2. The bit order of `card_sel_o` is [0] socket select, [1] register select.
- R8: When in sleep with the card-float bit set, `card_ctl_o` has enable 0 and drive value 0. `card_sel_o` equals `card_addr_sel` with enable 1.
- R9: `fast_osc_run` is 0 only when in sleep, with the oscillator-stop bit set and `slow_xtal_on` high. Otherwise it is 1.
- R10: Pin outputs, enables and `fast_osc_run` reflect the inputs and stored bits present at the previous rising edge. After an `rst` edge, all drive values, all enables and `fast_osc_run` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| wdt_rst | input | 1 | Synchronous watchdog reset, clears configuration |
| gpio_rst | input | 1 | Synchronous GPIO reset, clears configuration |
| reg_we | input | 1 | Configuration write strobe |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Configuration read data |
| sleep_in | input | 1 | Chip is in sleep |
| slow_xtal_on | input | 1 | Slow crystal is enabled |
| mem_func_cs | input | 6 | Functional chip selects |
| mem_func_we | input | 1 | Functional write enable |
| mem_func_oe | input | 1 | Functional output enable |
| mem_slp_cs | input | 5 | Sleep levels for chip selects 5..1 |
| card_func_ctl | input | 6 | Functional card control pins |
| card_slp_ctl | input | 6 | Sleep levels for card control pins |
| card_func_sel | input | 2 | Functional socket/register select |
| card_slp_sel | input | 2 | Sleep levels for socket/register select |
| card_addr_sel | input | 2 | Live address bits for socket/register select |
| mem_cs_o | output | 6 | Chip-select drive values |
| mem_cs_oe | output | 6 | Chip-select enables |
| mem_we_o | output | 1 | Write-enable drive value |
| mem_we_oe | output | 1 | Write-enable enable |
| mem_oe_o | output | 1 | Output-enable drive value |
| mem_oe_oe | output | 1 | Output-enable enable |
| card_ctl_o | output | 6 | Card control drive values |
| card_ctl_oe | output | 6 | Card control enables |
| card_sel_o | output | 2 | Socket/register select drive values |
| card_sel_oe | output | 2 | Socket/register select enables |
| fast_osc_run | output | 1 | Fast oscillator run enable |

## Verification
Register reads are combinational: the stored bits are due in the cycle after a write or reset edge. Pin outputs, enables and the oscillator flag are due one edge after the inputs that produce them, and they use the stored bits from before that edge. The bench drives inputs at the falling edge and predicts the registered result from those inputs and its model word. It updates the model only after the prediction, then compares at the next falling edge. A hardware reset in a stimulus cycle replaces the prediction with the all-ones reset pattern.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int CFG_W        = 32;
    localparam int BIT_OSC_STOP = 0;
    localparam int BIT_CARD_FLT = 1;
    localparam int BIT_MEM_FLT  = 2;
    localparam int CFG_USED     = 3;

    // Stored configuration; packed so bit 0 is the oscillator stop enable.
    typedef struct packed {
        logic mem_flt;
        logic card_flt;
        logic osc_stop;
    } spc_cfg_t;

    typedef enum logic [1:0] {
        GRP_AWAKE = 2'd0,
        GRP_DRIVE = 2'd1,
        GRP_FLOAT = 2'd2
    } spc_grp_mode_t;

    function automatic spc_cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
        spc_cfg_t c;
        c.osc_stop = w[BIT_OSC_STOP];
        c.card_flt = w[BIT_CARD_FLT];
        c.mem_flt  = w[BIT_MEM_FLT];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_to_word(input spc_cfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[BIT_OSC_STOP] = c.osc_stop;
        w[BIT_CARD_FLT] = c.card_flt;
        w[BIT_MEM_FLT]  = c.mem_flt;
        return w;
    endfunction

    function automatic spc_grp_mode_t grp_mode(input logic asleep, input logic flt);
        if (!asleep) return GRP_AWAKE;
        return flt ? GRP_FLOAT : GRP_DRIVE;
    endfunction

endpackage

// File: rtl/spc_cfg_reg.sv
module spc_cfg_reg
    import spc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wdt_rst,
    input  logic             gpio_rst,
    input  logic             reg_we,
    input  logic [CFG_W-1:0] reg_wdata,
    output logic [CFG_W-1:0] reg_rdata,
    output spc_cfg_t         cfg
);
    spc_cfg_t cfg_q;
    logic     any_rst;

    assign any_rst = rst | wdt_rst | gpio_rst;

    always_ff @(posedge clk) begin
        if (any_rst)
            cfg_q <= '0;
        else if (reg_we)
            cfg_q <= cfg_from_word(reg_wdata);
    end

    assign cfg       = cfg_q;
    assign reg_rdata = cfg_to_word(cfg_q);

    // R3: watchdog or GPIO reset clears the word, even against a write
    a_r3_soft_reset_clears: assert property (@(posedge clk) disable iff (rst)
        (wdt_rst || gpio_rst) |=> (reg_rdata[CFG_USED-1:0] == '0));

    // R1: a write lands on the next read
    a_r1_write_visible: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !wdt_rst && !gpio_rst) |=>
            (reg_rdata[CFG_USED-1:0] == $past(reg_wdata[CFG_USED-1:0])));

    // R2: reserved bits stay zero after any write
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_rdata[CFG_W-1:CFG_USED] == '0));
endmodule

// File: rtl/spc_mem_mux.sv
module spc_mem_mux
    import spc_pkg::*;
#(
    parameter int NCS = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sleep_in,
    input  logic           flt,
    input  logic [NCS-1:0] func_cs,
    input  logic           func_we,
    input  logic           func_oe,
    input  logic [NCS-2:0] slp_cs,
    output logic [NCS-1:0] cs_o,
    output logic [NCS-1:0] cs_oe,
    output logic           we_o,
    output logic           we_oe,
    output logic           oe_o,
    output logic           oe_oe
);
    spc_grp_mode_t  mode;
    logic [NCS-1:0] cs_d, cs_en_d;
    logic           we_d, we_en_d, oe_d, oe_en_d;

    assign mode = grp_mode(sleep_in, flt);

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        logic slp_level;
        if (i == 0) begin : g_forced
            assign slp_level = 1'b1;
        end else begin : g_prog
            assign slp_level = slp_cs[i-1];
        end
        always_comb begin
            unique case (mode)
                GRP_AWAKE: begin cs_d[i] = func_cs[i]; cs_en_d[i] = 1'b1; end
                GRP_DRIVE: begin cs_d[i] = slp_level;  cs_en_d[i] = 1'b1; end
                default:   begin cs_d[i] = 1'b0;       cs_en_d[i] = 1'b0; end
            endcase
        end
    end

    always_comb begin
        unique case (mode)
            GRP_AWAKE: begin
                we_d = func_we; we_en_d = 1'b1;
                oe_d = func_oe; oe_en_d = 1'b1;
            end
            GRP_DRIVE: begin
                we_d = 1'b1; we_en_d = 1'b1;
                oe_d = 1'b1; oe_en_d = 1'b1;
            end
            default: begin
                we_d = 1'b0; we_en_d = 1'b0;
                oe_d = 1'b0; oe_en_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_o  <= '1; cs_oe <= '1;
            we_o  <= 1'b1; we_oe <= 1'b1;
            oe_o  <= 1'b1; oe_oe <= 1'b1;
        end else begin
            cs_o  <= cs_d;  cs_oe <= cs_en_d;
            we_o  <= we_d;  we_oe <= we_en_d;
            oe_o  <= oe_d;  oe_oe <= oe_en_d;
        end
    end

    // R4: awake pins are enabled one clock later
    a_r4_mem_awake_enabled: assert property (@(posedge clk) disable iff (rst)
        !sleep_in |=> (&cs_oe && we_oe && oe_oe));

    // R5: forced-high pins in driven sleep
    a_r5_mem_forced_high: assert property (@(posedge clk) disable iff (rst)
        (sleep_in && !flt) |=> (cs_o[0] && we_o && oe_o && &cs_oe));

    // R6: floated group releases every pin
    a_r6_mem_float: assert property (@(posedge clk) disable iff (rst)
        (sleep_in && flt) |=> (cs_oe == '0 && !we_oe && !oe_oe));
endmodule

// File: rtl/spc_card_mux.sv
module spc_card_mux
    import spc_pkg::*;
#(
    parameter int NCTL = 6,
    parameter int NSEL = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep_in,
    input  logic            flt,
    input  logic [NCTL-1:0] func_ctl,
    input  logic [NCTL-1:0] slp_ctl,
    input  logic [NSEL-1:0] func_sel,
    input  logic [NSEL-1:0] slp_sel,
    input  logic [NSEL-1:0] addr_sel,
    output logic [NCTL-1:0] ctl_o,
    output logic [NCTL-1:0] ctl_oe,
    output logic [NSEL-1:0] sel_o,
    output logic [NSEL-1:0] sel_oe
);
    spc_grp_mode_t   mode;
    logic [NCTL-1:0] ctl_d, ctl_en_d;
    logic [NSEL-1:0] sel_d;

    assign mode = grp_mode(sleep_in, flt);

    always_comb begin
        unique case (mode)
            GRP_AWAKE: begin ctl_d = func_ctl; ctl_en_d = '1; sel_d = func_sel; end
            GRP_DRIVE: begin ctl_d = slp_ctl;  ctl_en_d = '1; sel_d = slp_sel;  end
            default:   begin ctl_d = '0;       ctl_en_d = '0; sel_d = addr_sel; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_o <= '1; ctl_oe <= '1;
            sel_o <= '1; sel_oe <= '1;
        end else begin
            ctl_o <= ctl_d; ctl_oe <= ctl_en_d;
            sel_o <= sel_d; sel_oe <= '1;
        end
    end

    // R8: selects track the address bus while the controls float
    a_r8_sel_follows_addr: assert property (@(posedge clk) disable iff (rst)
        (sleep_in && flt) |=> (sel_o == $past(addr_sel) && ctl_oe == '0));

    // R7: programmed levels reach the pins
    a_r7_card_drive: assert property (@(posedge clk) disable iff (rst)
        (sleep_in && !flt) |=> (ctl_o == $past(slp_ctl) && &ctl_oe));
endmodule

// File: rtl/spc_osc_gate.sv
module spc_osc_gate (
    input  logic clk,
    input  logic rst,
    input  logic sleep_in,
    input  logic stop_en,
    input  logic slow_xtal_on,
    output logic fast_osc_run
);
    logic stop_req;

    assign stop_req = sleep_in & stop_en & slow_xtal_on;

    always_ff @(posedge clk) begin
        if (rst) fast_osc_run <= 1'b1;
        else     fast_osc_run <= ~stop_req;
    end

    // R9: no slow crystal vetoes the stop request
    a_r9_xtal_veto: assert property (@(posedge clk) disable iff (rst)
        !slow_xtal_on |=> fast_osc_run);

    // R9: awake chip keeps the oscillator running
    a_r9_awake_runs: assert property (@(posedge clk) disable iff (rst)
        !sleep_in |=> fast_osc_run);
endmodule

// File: rtl/sleep_pin_ctrl.sv
module sleep_pin_ctrl
    import spc_pkg::*;
#(
    parameter int NCS  = 6,
    parameter int NCTL = 6,
    parameter int NSEL = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wdt_rst,
    input  logic            gpio_rst,
    input  logic            reg_we,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            sleep_in,
    input  logic            slow_xtal_on,
    input  logic [NCS-1:0]  mem_func_cs,
    input  logic            mem_func_we,
    input  logic            mem_func_oe,
    input  logic [NCS-2:0]  mem_slp_cs,
    input  logic [NCTL-1:0] card_func_ctl,
    input  logic [NCTL-1:0] card_slp_ctl,
    input  logic [NSEL-1:0] card_func_sel,
    input  logic [NSEL-1:0] card_slp_sel,
    input  logic [NSEL-1:0] card_addr_sel,
    output logic [NCS-1:0]  mem_cs_o,
    output logic [NCS-1:0]  mem_cs_oe,
    output logic            mem_we_o,
    output logic            mem_we_oe,
    output logic            mem_oe_o,
    output logic            mem_oe_oe,
    output logic [NCTL-1:0] card_ctl_o,
    output logic [NCTL-1:0] card_ctl_oe,
    output logic [NSEL-1:0] card_sel_o,
    output logic [NSEL-1:0] card_sel_oe,
    output logic            fast_osc_run
);
    spc_cfg_t cfg;

    spc_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .wdt_rst(wdt_rst), .gpio_rst(gpio_rst),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg(cfg)
    );

    spc_mem_mux #(.NCS(NCS)) u_mem (
        .clk(clk), .rst(rst), .sleep_in(sleep_in), .flt(cfg.mem_flt),
        .func_cs(mem_func_cs), .func_we(mem_func_we), .func_oe(mem_func_oe),
        .slp_cs(mem_slp_cs),
        .cs_o(mem_cs_o), .cs_oe(mem_cs_oe), .we_o(mem_we_o), .we_oe(mem_we_oe),
        .oe_o(mem_oe_o), .oe_oe(mem_oe_oe)
    );

    spc_card_mux #(.NCTL(NCTL), .NSEL(NSEL)) u_card (
        .clk(clk), .rst(rst), .sleep_in(sleep_in), .flt(cfg.card_flt),
        .func_ctl(card_func_ctl), .slp_ctl(card_slp_ctl),
        .func_sel(card_func_sel), .slp_sel(card_slp_sel), .addr_sel(card_addr_sel),
        .ctl_o(card_ctl_o), .ctl_oe(card_ctl_oe),
        .sel_o(card_sel_o), .sel_oe(card_sel_oe)
    );

    spc_osc_gate u_osc (
        .clk(clk), .rst(rst), .sleep_in(sleep_in), .stop_en(cfg.osc_stop),
        .slow_xtal_on(slow_xtal_on), .fast_osc_run(fast_osc_run)
    );

    // R10: hardware reset leaves every pin driven high and enabled
    a_r10_reset_pattern: assert property (@(posedge clk)
        rst |=> (&mem_cs_o && &mem_cs_oe && &card_ctl_oe && fast_osc_run));
endmodule

// File: tb/test_sleep_pin_ctrl.sv
`timescale 1ns/1ps
module test_sleep_pin_ctrl;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, wdt_rst, gpio_rst, reg_we, sleep_in, slow_xtal_on;
    logic [31:0] reg_wdata, reg_rdata;
    logic [5:0] mem_func_cs, card_func_ctl, card_slp_ctl;
    logic mem_func_we, mem_func_oe;
    logic [4:0] mem_slp_cs;
    logic [1:0] card_func_sel, card_slp_sel, card_addr_sel;
    logic [5:0] mem_cs_o, mem_cs_oe, card_ctl_o, card_ctl_oe;
    logic mem_we_o, mem_we_oe, mem_oe_o, mem_oe_oe, fast_osc_run;
    logic [1:0] card_sel_o, card_sel_oe;

    sleep_pin_ctrl i_sleep_pin_ctrl (.*);

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [2:0] mcfg;
    logic [31:0] e_mem, e_card;  // packed expected groups
    logic e_osc;
    string t_mem, t_card, t_osc;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // memory group: {cs_o, cs_oe, we_o, we_oe, oe_o, oe_oe}
    function automatic logic [31:0] pred_mem(input logic slp, input logic flt);
        logic [5:0] cs;
        if (!slp) return {16'd0, mem_func_cs, 6'h3f, mem_func_we, 1'b1, mem_func_oe, 1'b1};
        if (flt)  return 32'd0;
        cs = {mem_slp_cs, 1'b1};                     // R5 cs0 forced high
        return {16'd0, cs, 6'h3f, 4'hf};
    endfunction

    // card group: {ctl_o, ctl_oe, sel_o, sel_oe}
    function automatic logic [31:0] pred_card(input logic slp, input logic flt);
        if (!slp) return {16'd0, card_func_ctl, 6'h3f, card_func_sel, 2'b11};
        if (flt)  return {16'd0, 6'h00, 6'h00, card_addr_sel, 2'b11};
        return {16'd0, card_slp_ctl, 6'h3f, card_slp_sel, 2'b11};
    endfunction

    function automatic string mode_tag(input logic flt, input string dtag, input string ftag);
        if (!sleep_in) return "R4";
        return flt ? ftag : dtag;
    endfunction

    // Prediction for the coming edge, then model register update.
    task automatic predict();
        if (rst) begin
            e_mem = {16'd0, 6'h3f, 6'h3f, 4'hf};
            e_card = {16'd0, 6'h3f, 6'h3f, 2'b11, 2'b11};
            e_osc = 1'b1;
            t_mem = "R10"; t_card = "R10"; t_osc = "R10";
        end else begin
            e_mem = pred_mem(sleep_in, mcfg[2]);
            e_card = pred_card(sleep_in, mcfg[1]);
            e_osc = !(sleep_in && mcfg[0] && slow_xtal_on);
            t_mem = mode_tag(mcfg[2], "R5", "R6");
            t_card = mode_tag(mcfg[1], "R7", "R8");
            t_osc = "R9";
        end
        if (rst || wdt_rst || gpio_rst) mcfg = 3'b000;   // R3
        else if (reg_we) mcfg = reg_wdata[2:0];
    endtask

    task automatic check_all();
        chk(t_mem, {16'd0, mem_cs_o, mem_cs_oe, mem_we_o, mem_we_oe, mem_oe_o, mem_oe_oe}, e_mem);
        chk(t_card, {16'd0, card_ctl_o, card_ctl_oe, card_sel_o, card_sel_oe}, e_card);
        chk(t_osc, {31'd0, fast_osc_run}, {31'd0, e_osc});
        chk("R1", {29'd0, reg_rdata[2:0]}, {29'd0, mcfg});
        chk("R2", {3'd0, reg_rdata[31:3]}, 32'd0);
    endtask

    task automatic step();
        predict();
        @(negedge clk);
        check_all();
    endtask

    task automatic rand_pins();
        mem_func_cs = 6'($urandom); mem_func_we = 1'($urandom); mem_func_oe = 1'($urandom);
        mem_slp_cs = 5'($urandom); card_func_ctl = 6'($urandom); card_slp_ctl = 6'($urandom);
        card_func_sel = 2'($urandom); card_slp_sel = 2'($urandom); card_addr_sel = 2'($urandom);
    endtask

    task automatic idle();
        rst = 0; wdt_rst = 0; gpio_rst = 0; reg_we = 0; reg_wdata = 32'($urandom);
    endtask

    initial begin
        void'($urandom(32'd1234));
        mcfg = 3'b000;
        idle(); rst = 1; sleep_in = 0; slow_xtal_on = 1; rand_pins();
        @(negedge clk);
        step();                                      // R10 reset state
        idle(); step();                              // R4 awake passthrough
        // R2: write all ones, only three bits survive
        reg_we = 1; reg_wdata = 32'hffff_ffff; step();
        // R5/R7/R9 with both floats clear, osc stop set
        idle(); reg_we = 1; reg_wdata = 32'h0000_0001; step();
        idle(); sleep_in = 1; rand_pins(); step(); step();
        // R9 veto: slow crystal off
        slow_xtal_on = 0; step(); slow_xtal_on = 1;
        // R6/R8 both floats set
        reg_we = 1; reg_wdata = 32'h0000_0007; step();
        idle(); rand_pins(); step(); step();
        // R3: watchdog against a write, then GPIO reset
        reg_we = 1; wdt_rst = 1; reg_wdata = 32'h7; step();
        idle(); reg_we = 1; reg_wdata = 32'h6; step();
        idle(); gpio_rst = 1; step();
        idle(); sleep_in = 0; step();
        // constrained random
        for (int n = 0; n < 3000; n++) begin
            idle();
            rst = ($urandom % 80) == 0;
            wdt_rst = ($urandom % 40) == 0;
            gpio_rst = ($urandom % 40) == 0;
            reg_we = ($urandom % 6) == 0;
            if (($urandom % 10) == 0) sleep_in = ~sleep_in;
            slow_xtal_on = ($urandom % 5) != 0;
            rand_pins();
            step();
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule